// File: doc/BRIEF.md
# DRAM Error Address De-hash Normalizer

This block converts the address captured by a DRAM error report into a normalized address. The captured address packs a stack identifier, a pseudochannel bit, a row, a bank and a column. Before capture, the memory controller scrambled the four bank bits and the pseudochannel bit with programmable XOR hashes. The block removes that scrambling and then moves each field to its fixed place in a 31-bit normalized address. Translation to a system address happens downstream.

Software writes six configuration registers once at initialization: one hash register per bank bit, one pseudochannel hash register and one extended-bank mask register. A per-request mode bit picks either conversion or plain pass-through. Requests enter through a valid/ready handshake. The result is held in a single output register until the consumer accepts it.

That output register is run by a two-state machine. In `OS_EMPTY` the register holds nothing. In `OS_FULL` it holds a result. The transition *load* (`OS_EMPTY` to `OS_FULL`) fires on an accepted request. *drain* (`OS_FULL` to `OS_EMPTY`) fires when the consumer takes the result and no new request arrives. *refill* (`OS_FULL` to `OS_FULL`) fires when the result is taken and a new request is accepted in the same cycle. *stall* keeps `OS_FULL` while `out_ready` is low.

Top module: `dram_addr_normalizer`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and all six configuration registers are zero, so every hash is disabled.
- R2: Input fields are: bit 0 zero, col = bits 5:1, bank = bits 9:6, row = bits 24:10, pc = bit 25, sid = bits 27:26. With hashing disabled, a conversion yields `{sid, row[13:0], col[4], bank[1:0], bank[3:2], col[3:2], pc, col[1:0], 5'b00000}`.
- R3: A hash register has this layout: enable in bit 0, column mask in bits 13:1, row mask in bits 31:14. When bank hash register i is enabled, bank bit i is inverted by the XOR of the parity of (col AND column mask) and the parity of (row AND row mask).
- R4: A bank hash register whose enable bit is 0 leaves its bank bit unchanged, whatever its masks hold.
- R5: When the pseudochannel hash register is enabled, pc is inverted by the XOR of three parities: col AND its column mask, row AND its row mask, and an extended bank value AND the 6-bit bank mask.
- R6: The extended bank value is the already de-hashed bank in bits 3:0, a zero in bit 4, and sid in bits 6:5. Only bits 5:0 meet the mask, so sid[1] never contributes. The bank mask register holds its mask in bits 5:0. The sid bits never enter the placed bank field.
- R7: Row bit 14 does not appear in the result. Mask bits beyond a field's width (column mask bits above 4, row mask bits above 14) have no effect.
- R8: When `in_convert` is 0, the result is the input address zero-extended to 31 bits.
- R9: A result is presented with `out_valid` high in the cycle after its request is accepted. It stays valid and unchanged until `out_ready` is high.
- R10: `in_ready` is high when the output register is empty or is being read in the same cycle. A held, unread result is never overwritten.
- R11: Register offsets are: bank hash registers at 0x00, 0x04, 0x08 and 0x0C, pseudochannel hash at 0x10, bank mask at 0x14. A write to any other offset, or to an offset that is not a multiple of 4, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 5 | Configuration byte offset |
| cfg_wr_data | input | 32 | Configuration write data |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_convert | input | 1 | 1 converts, 0 passes the address through |
| in_addr | input | 28 | Captured DRAM error address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 31 | Normalized or passed-through address |

## Verification
Every result is due exactly one clock edge after the edge that accepts its request. A configuration write affects any request accepted after the edge that performs the write. The bench drives inputs one nanosecond after a rising edge and reads handshakes at the falling edge. A request counts as accepted at the falling edge where `in_valid` and `in_ready` are both high. At that moment the bench queues the value it computes for that request. At the next falling edge it checks that `out_valid` is high. It pops and compares a queued value at each falling edge where `out_valid` and `out_ready` are both high. When a result is stalled, the bench checks at the next falling edge that the held value is unchanged and that `in_ready` stays low.

// File: rtl/dhn_pkg.sv
package dhn_pkg;

    parameter int ADDR_IN_W     = 28;
    parameter int NA_W          = 31;
    parameter int COL_W         = 5;
    parameter int BANK_W        = 4;
    parameter int ROW_W         = 15;
    parameter int NA_ROW_W      = 14;
    parameter int SID_W         = 2;
    parameter int CMASK_W       = 13;
    parameter int RMASK_W       = 18;
    parameter int BMASK_W       = 6;
    parameter int CFG_AW        = 5;
    parameter int REG_W         = 1 + CMASK_W + RMASK_W;

    localparam int COL_LSB      = 1;
    localparam int BANK_LSB     = COL_LSB + COL_W;
    localparam int ROW_LSB      = BANK_LSB + BANK_W;
    localparam int PC_POS       = ROW_LSB + ROW_W;
    localparam int SID_LSB      = PC_POS + 1;
    localparam int EXT_BANK_W   = BANK_W + 1 + SID_W;
    localparam int NA_ZERO_W    = 5;

    typedef struct packed {
        logic [RMASK_W-1:0] row_mask;
        logic [CMASK_W-1:0] col_mask;
        logic               enable;
    } hash_cfg_t;

    typedef struct packed {
        logic [SID_W-1:0]  sid;
        logic              pc;
        logic [ROW_W-1:0]  row;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
    } dram_fields_t;

    typedef enum logic {
        OS_EMPTY = 1'b0,
        OS_FULL  = 1'b1
    } out_state_t;

endpackage

// File: rtl/dhn_cfg_regs.sv
module dhn_cfg_regs
    import dhn_pkg::*;
#(
    parameter int NUM_BANK_HASH = BANK_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CFG_AW-1:0]   wr_addr,
    input  logic [REG_W-1:0]    wr_data,
    output hash_cfg_t           bank_cfg [NUM_BANK_HASH],
    output hash_cfg_t           pc_cfg,
    output logic [BMASK_W-1:0]  bank_mask
);

    localparam int IDX_W    = CFG_AW - 2;
    localparam int PC_IDX   = NUM_BANK_HASH;
    localparam int MASK_IDX = NUM_BANK_HASH + 1;

    logic             aligned;
    logic [IDX_W-1:0] word_idx;

    assign aligned  = (wr_addr[1:0] == 2'b00);
    assign word_idx = wr_addr[CFG_AW-1:2];

    for (genvar g = 0; g < NUM_BANK_HASH; g++) begin : g_bank_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_cfg[g] <= '0;
            end else if (wr_en && aligned && (int'(word_idx) == g)) begin
                bank_cfg[g] <= hash_cfg_t'(wr_data);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_cfg <= '0;
        end else if (wr_en && aligned && (int'(word_idx) == PC_IDX)) begin
            pc_cfg <= hash_cfg_t'(wr_data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_mask <= '0;
        end else if (wr_en && aligned && (int'(word_idx) == MASK_IDX)) begin
            bank_mask <= wr_data[BMASK_W-1:0];
        end
    end

    // R11: a write to the pseudochannel offset lands in that register
    p_pc_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CFG_AW'(PC_IDX * 4)) |=> (pc_cfg == $past(wr_data)));

    // R11: misaligned writes leave the registers alone
    p_misaligned_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[1:0] != 2'b00) |=> ($stable(pc_cfg) && $stable(bank_mask)));

endmodule

// File: rtl/dhn_dehash.sv
module dhn_dehash
    import dhn_pkg::*;
#(
    parameter int NUM_BANK_HASH = BANK_W
) (
    input  dram_fields_t        raw,
    input  hash_cfg_t           bank_cfg [NUM_BANK_HASH],
    input  hash_cfg_t           pc_cfg,
    input  logic [BMASK_W-1:0]  bank_mask,
    output dram_fields_t        fixed
);

    logic [BANK_W-1:0]     bank_flip;
    logic [BANK_W-1:0]     bank_clean;
    logic [EXT_BANK_W-1:0] ext_bank;
    logic                  pc_flip;

    // Stage one: each bank bit has its own independent parity term.
    for (genvar g = 0; g < NUM_BANK_HASH; g++) begin : g_bank_hash
        always_comb begin
            bank_flip[g] = bank_cfg[g].enable &
                           ((^(raw.col & bank_cfg[g].col_mask[COL_W-1:0])) ^
                            (^(raw.row & bank_cfg[g].row_mask[ROW_W-1:0])));
        end
    end

    assign bank_clean = raw.bank ^ bank_flip;

    // Stage two: the pseudochannel term uses the cleaned bank with the stack bits on top.
    assign ext_bank = {raw.sid, 1'b0, bank_clean};

    always_comb begin
        pc_flip = pc_cfg.enable &
                  ((^(raw.col & pc_cfg.col_mask[COL_W-1:0])) ^
                   (^(raw.row & pc_cfg.row_mask[ROW_W-1:0])) ^
                   (^(ext_bank[BMASK_W-1:0] & bank_mask)));
    end

    always_comb begin
        fixed      = raw;
        fixed.bank = bank_clean;
        fixed.pc   = raw.pc ^ pc_flip;
    end

endmodule

// File: rtl/dhn_pack.sv
module dhn_pack
    import dhn_pkg::*;
(
    input  dram_fields_t     fields,
    output logic [NA_W-1:0]  norm
);

    always_comb begin
        norm = {fields.sid,
                fields.row[NA_ROW_W-1:0],
                fields.col[4],
                fields.bank[1:0],
                fields.bank[3:2],
                fields.col[3:2],
                fields.pc,
                fields.col[1:0],
                {NA_ZERO_W{1'b0}}};
    end

endmodule

// File: rtl/dhn_out_stage.sv
module dhn_out_stage
    import dhn_pkg::*;
#(
    parameter int DATA_W = NA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [DATA_W-1:0] up_data,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [DATA_W-1:0] dn_data
);

    out_state_t state_q, state_d;
    logic       load;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_EMPTY: if (up_valid) state_d = OS_FULL;                   // load
            OS_FULL:  if (dn_ready && !up_valid) state_d = OS_EMPTY;     // drain
                      else state_d = OS_FULL;                            // refill / stall
            default:  state_d = OS_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OS_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            OS_EMPTY: begin
                dn_valid = 1'b0;
                up_ready = 1'b1;
            end
            OS_FULL: begin
                dn_valid = 1'b1;
                up_ready = dn_ready;
            end
            default: begin
                dn_valid = 1'b0;
                up_ready = 1'b0;
            end
        endcase
    end

    assign load = up_valid && up_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    dn_data <= '0;
        else if (load) dn_data <= up_data;
    end

    // R9: an accepted request is presented on the next cycle
    p_result_next_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready) |=> dn_valid);

    // R9: a stalled result holds its value
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

endmodule

// File: rtl/dram_addr_normalizer.sv
module dram_addr_normalizer
    import dhn_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr_en,
    input  logic [CFG_AW-1:0]     cfg_wr_addr,
    input  logic [REG_W-1:0]      cfg_wr_data,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic                  in_convert,
    input  logic [ADDR_IN_W-1:0]  in_addr,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [NA_W-1:0]       out_addr
);

    localparam int NUM_BANK_HASH = BANK_W;

    hash_cfg_t          bank_cfg [NUM_BANK_HASH];
    hash_cfg_t          pc_cfg;
    logic [BMASK_W-1:0] bank_mask;
    dram_fields_t       raw;
    dram_fields_t       fixed;
    logic [NA_W-1:0]    norm;
    logic [NA_W-1:0]    result;

    dhn_cfg_regs #(.NUM_BANK_HASH(NUM_BANK_HASH)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_addr   (cfg_wr_addr),
        .wr_data   (cfg_wr_data),
        .bank_cfg  (bank_cfg),
        .pc_cfg    (pc_cfg),
        .bank_mask (bank_mask)
    );

    assign raw = dram_fields_t'(in_addr[ADDR_IN_W-1:COL_LSB]);

    dhn_dehash #(.NUM_BANK_HASH(NUM_BANK_HASH)) u_dehash (
        .raw       (raw),
        .bank_cfg  (bank_cfg),
        .pc_cfg    (pc_cfg),
        .bank_mask (bank_mask),
        .fixed     (fixed)
    );

    dhn_pack u_pack (
        .fields (fixed),
        .norm   (norm)
    );

    assign result = in_convert ? norm : {{(NA_W-ADDR_IN_W){1'b0}}, in_addr};

    dhn_out_stage #(.DATA_W(NA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .up_data  (result),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_data  (out_addr)
    );

    // R4: a disabled bank hash register passes its bank bit straight through
    for (genvar g = 0; g < NUM_BANK_HASH; g++) begin : g_bypass_chk
        p_bank_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!bank_cfg[g].enable) |-> (fixed.bank[g] == raw.bank[g]));
    end

    // R10: an unread result blocks new requests
    p_no_overwrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/tb_dram_addr_normalizer.sv
module tb_dram_addr_normalizer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [4:0]  cfg_wr_addr = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_convert = 1'b0;
    logic [27:0] in_addr = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [30:0] out_addr;

    int checks = 0;
    int fails  = 0;
    bit bp_en  = 1'b0;
    bit done   = 1'b0;

    logic [31:0] sh_bank [4];
    logic [31:0] sh_pc;
    logic [5:0]  sh_bm;

    logic [30:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    dram_addr_normalizer dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_convert(in_convert), .in_addr(in_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [30:0] model(input logic [27:0] a, input logic conv);
        logic [4:0]  col;
        logic [3:0]  bank;
        logic [14:0] row;
        logic        pc;
        logic [1:0]  sid;
        logic        p;
        logic [6:0]  ext;
        if (!conv) return {3'b000, a};
        col = a[5:1]; bank = a[9:6]; row = a[24:10]; pc = a[25]; sid = a[27:26];
        for (int i = 0; i < 4; i++) begin
            if (sh_bank[i][0]) begin
                p = 1'b0;
                for (int b = 0; b < 5; b++)  p ^= col[b] & sh_bank[i][1+b];
                for (int b = 0; b < 15; b++) p ^= row[b] & sh_bank[i][14+b];
                bank[i] = bank[i] ^ p;
            end
        end
        if (sh_pc[0]) begin
            p = 1'b0;
            for (int b = 0; b < 5; b++)  p ^= col[b] & sh_pc[1+b];
            for (int b = 0; b < 15; b++) p ^= row[b] & sh_pc[14+b];
            ext = {sid, 1'b0, bank};
            for (int b = 0; b < 6; b++)  p ^= ext[b] & sh_bm[b];
            pc = pc ^ p;
        end
        return {sid, row[13:0], col[4], bank[1:0], bank[3:2], col[3:2], pc, col[1:0], 5'b00000};
    endfunction

    task automatic cfg_write(input logic [4:0] off, input logic [31:0] data);
        @(posedge clk); #1;
        cfg_wr_en = 1'b1; cfg_wr_addr = off; cfg_wr_data = data;
        @(posedge clk); #1;
        cfg_wr_en = 1'b0;
        if (off[1:0] == 2'b00) begin
            if (off[4:2] < 3'd4)       sh_bank[off[4:2]] = data;
            else if (off[4:2] == 3'd4) sh_pc = data;
            else if (off[4:2] == 3'd5) sh_bm = data[5:0];
        end
    endtask

    // Driver: pushes the expected result when the request is accepted.
    task automatic send(input logic [27:0] a, input logic conv, input string tag);
        bit acc = 1'b0;
        @(posedge clk); #1;
        in_valid = 1'b1; in_addr = a; in_convert = conv;
        while (!acc) begin
            @(negedge clk);
            if (in_ready) begin
                acc = 1'b1;
                exp_q.push_back(model(a, conv));
                tag_q.push_back(tag);
            end else begin
                @(posedge clk); #1;
            end
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b1, "R9 latency", {31'd0, out_valid}, 32'd1);
    endtask

    // Back-pressure generator
    always @(posedge clk) begin
        #1;
        out_ready = bp_en ? (($urandom % 3) != 0) : 1'b1;
    end

    // Monitor: compares results and the stall behaviour.
    bit          held = 1'b0;
    logic [30:0] held_val;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (held) begin
                check(out_valid === 1'b1 && out_addr === held_val, "R9 hold",
                      {1'b0, out_addr}, {1'b0, held_val});
            end
            held = 1'b0;
            if (out_valid && !out_ready) begin
                held = 1'b1;
                held_val = out_addr;
                check(in_ready === 1'b0, "R10 no overwrite", {31'd0, in_ready}, 32'd0);
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected result", {1'b0, out_addr}, 32'd0);
                end else begin
                    logic [30:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_addr === e, t, {1'b0, out_addr}, {1'b0, e});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) sh_bank[i] = '0;
        sh_pc = '0; sh_bm = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(out_valid === 1'b0, "R1 out_valid", {31'd0, out_valid}, 32'd0);
        check(in_ready === 1'b1, "R1 in_ready", {31'd0, in_ready}, 32'd1);
        send(28'h1F_FFFE, 1'b1, "R1 hash disabled at reset");
        // R2: pure permutation, single fields
        send(28'h000_003E, 1'b1, "R2 column");
        send(28'h000_03C0, 1'b1, "R2 bank");
        send(28'h200_0000, 1'b1, "R2 pc");
        send(28'hC00_0000, 1'b1, "R2 sid");
        send(28'h1FF_FC00, 1'b1, "R2 row");
        // R7: row bit 14 dropped
        send(28'h100_0000, 1'b1, "R7 row bit 14");
        // R8: pass-through
        send(28'hFFF_FFFF, 1'b0, "R8 pass all ones");
        send(28'hA5C_3E96, 1'b0, "R8 pass pattern");
        // R3/R4/R7: bank hashing
        cfg_write(5'h00, {18'd0, 13'b0_0000_0000_0101, 1'b1});
        cfg_write(5'h04, 32'hFFFF_FFFE);
        cfg_write(5'h08, {18'b00_0000_0000_1000_0001, 13'd0, 1'b1});
        cfg_write(5'h0C, {18'b11_1000_0000_0000_0000, 13'b1_1111_1110_0000, 1'b1});
        send({2'b00, 1'b0, 15'h0000, 4'h0, 5'b00001, 1'b0}, 1'b1, "R3 bank0 column parity odd");
        send({2'b00, 1'b0, 15'h0000, 4'h1, 5'b00101, 1'b0}, 1'b1, "R3 bank0 column parity even");
        send({2'b00, 1'b0, 15'h0081, 4'h4, 5'b00000, 1'b0}, 1'b1, "R3 bank2 row parity even");
        send({2'b00, 1'b0, 15'h0001, 4'h0, 5'b00000, 1'b0}, 1'b1, "R3 bank2 row parity odd");
        send({2'b00, 1'b0, 15'h7FFF, 4'h2, 5'b11111, 1'b0}, 1'b1, "R4 bank1 disabled");
        send({2'b00, 1'b0, 15'h4000, 4'h8, 5'b11110, 1'b0}, 1'b1, "R7 masks beyond width");
        // R5/R6: pseudochannel hash
        cfg_write(5'h10, {18'b00_0000_0000_0000_0010, 13'b0_0000_0000_0010, 1'b1});
        cfg_write(5'h14, 32'h0000_0020);
        send({2'b01, 1'b0, 15'h0000, 4'h0, 5'b00000, 1'b0}, 1'b1, "R6 sid0 in bank term");
        send({2'b10, 1'b0, 15'h0000, 4'h0, 5'b00000, 1'b0}, 1'b1, "R6 sid1 outside mask");
        send({2'b00, 1'b1, 15'h0000, 4'h0, 5'b00010, 1'b0}, 1'b1, "R5 column term");
        send({2'b00, 1'b0, 15'h0002, 4'h0, 5'b00000, 1'b0}, 1'b1, "R5 row term");
        cfg_write(5'h14, 32'h0000_0001);
        send({2'b00, 1'b0, 15'h0000, 4'h0, 5'b00001, 1'b0}, 1'b1, "R6 de-hashed bank feeds pc");
        send({2'b11, 1'b1, 15'h5A5A, 4'hF, 5'b10101, 1'b0}, 1'b1, "R6 mixed");
        // R11: ignored offsets
        cfg_write(5'h18, 32'hFFFF_FFFF);
        cfg_write(5'h1C, 32'hFFFF_FFFF);
        cfg_write(5'h12, 32'h0000_0000);
        cfg_write(5'h05, 32'h0000_0000);
        send({2'b01, 1'b0, 15'h0003, 4'h3, 5'b00011, 1'b0}, 1'b1, "R11 ignored writes");
        cfg_write(5'h10, 32'h0000_0000);
        send({2'b01, 1'b1, 15'h0003, 4'h3, 5'b00011, 1'b0}, 1'b1, "R11 pc register cleared");
        // R9/R10: random traffic under back-pressure
        bp_en = 1'b1;
        cfg_write(5'h10, 32'h1234_5679);
        cfg_write(5'h14, 32'h0000_002B);
        for (int n = 0; n < 300; n++) begin
            send(28'($urandom), 1'(($urandom % 4) != 0), "R10 back-pressure traffic");
        end
        bp_en = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule